// File: doc/BRIEF.md
# Oldest-First Issue Queue with Full-Queue Penalty Zone

This block holds micro-ops waiting for their operands and hands one of them per cycle to the execution port it serves. Each micro-op arrives with an identifier and up to two source tags. A source is either already available at arrival or marked pending. A single broadcast bus announces produced results. Each broadcast carries a result tag and a flag that says whether the producer has a one-cycle latency. Matching sources become available, and an entry is issuable once both of its sources are available. Among issuable entries the one that has waited longest is always sent first.

Slots are kept in arrival order. Position 0 holds the oldest entry, and an issued entry is squeezed out in the cycle it leaves. Whenever every slot is occupied, the oldest few positions form a penalty zone. An entry in that zone whose last missing source was supplied by a one-cycle producer waits one extra cycle before it may issue. Sources supplied by slower producers cause no such wait. A flush input empties the queue at once.

Top module: `age_issue_queue`

## Requirements
- R1: After reset the queue is empty: `issue_valid` is 0 and `disp_full` is 0.
- R2: A dispatch is taken only while `disp_full` is 0. `disp_full` is 1 exactly when all DEPTH (16) slots are occupied. A refused micro-op is dropped and never issues, and the occupancy never exceeds DEPTH.
- R3: A pending source becomes available when a broadcast with `wake_valid`=1 carries its tag, including in the same cycle as the source's own dispatch. An entry whose last source is supplied in cycle t can issue in cycle t+1.
- R4: When several entries are issuable, `issue_id` is the identifier of the one dispatched earliest.
- R5: At most one entry issues per cycle. `issue_valid`/`issue_id` are combinational from the queue state, and the issued entry's slot is free from the next cycle on.
- R6: While the queue is full, an entry in one of the SLOW_N (4) oldest positions whose last source was supplied by a broadcast with `wake_fast`=1 issues one cycle later than normal. A younger issuable entry may issue in its place in that cycle.
- R7: No extra cycle is added when the last source came from a broadcast with `wake_fast`=0, when the queue is not full, when the entry lies outside the SLOW_N oldest positions, or when both sources were available at dispatch.
- R8: While `flush` is 1, nothing issues and no dispatch is taken. From the next cycle the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the queue, suppress issue and dispatch this cycle |
| disp_valid | input | 1 | A micro-op is offered for dispatch |
| disp_id | input | 8 | Identifier of the offered micro-op |
| disp_tag0 | input | 6 | Tag of source 0 |
| disp_rdy0 | input | 1 | Source 0 already available |
| disp_tag1 | input | 6 | Tag of source 1 |
| disp_rdy1 | input | 1 | Source 1 already available (tie to 1 if unused) |
| disp_full | output | 1 | All slots occupied; dispatch refused |
| wake_valid | input | 1 | A result broadcast is present |
| wake_tag | input | 6 | Tag of the broadcast result |
| wake_fast | input | 1 | Broadcast comes from a one-cycle producer |
| issue_valid | output | 1 | An entry issues this cycle |
| issue_id | output | 8 | Identifier of the issuing entry |

## Verification
The assertions check on every cycle that the grant is one-hot and goes to the lowest issuable position, and that issuable entries never go unserved outside a flush. They also check that a full queue admits nothing, that a flush leaves the queue empty, and that any entry held back by the penalty zone leads to an issue in the next cycle. The exact cycle on which each micro-op leaves can only be shown by the bench. This covers same-cycle wakeup at dispatch, the choice of a younger entry while older ones pay the penalty, the absence of the penalty after slow producers or below full, and dropped dispatches. The bench compares every cycle against an independent arrival-ordered model, running directed sequences and a long random mix.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

  localparam int IQ_TAG_W = 6;
  localparam int IQ_ID_W  = 8;

  typedef struct packed {
    logic [IQ_ID_W-1:0]  id;
    logic [IQ_TAG_W-1:0] tag0;
    logic                rdy0;
    logic [IQ_TAG_W-1:0] tag1;
    logic                rdy1;
    logic                fresh;   // became issuable at the last edge via a one-cycle producer
  } iq_ent_t;

  // A pending source is satisfied by a matching broadcast.
  function automatic logic tag_hit(input logic rdy, input logic [IQ_TAG_W-1:0] tag,
                                   input logic wv, input logic [IQ_TAG_W-1:0] wtag);
    return !rdy && wv && (tag == wtag);
  endfunction

  function automatic logic ent_ready(input iq_ent_t e);
    return e.rdy0 && e.rdy1;
  endfunction

  // Penalty applies to freshly woken entries in the oldest positions of a full queue.
  function automatic logic slow_blocked(input iq_ent_t e, input logic full,
                                        input int unsigned pos, input int unsigned slow_n);
    return e.fresh && full && (pos < slow_n);
  endfunction

endpackage

// File: rtl/iq_wake_cell.sv
module iq_wake_cell
  import iqs_pkg::*;
(
  input  iq_ent_t              cur,
  input  logic                 wake_valid,
  input  logic [IQ_TAG_W-1:0]  wake_tag,
  input  logic                 wake_fast,
  output iq_ent_t              nxt
);
  logic hit0, hit1, became_ready;

  assign hit0 = tag_hit(cur.rdy0, cur.tag0, wake_valid, wake_tag);
  assign hit1 = tag_hit(cur.rdy1, cur.tag1, wake_valid, wake_tag);
  assign became_ready = !ent_ready(cur) && (cur.rdy0 || hit0) && (cur.rdy1 || hit1);

  always_comb begin
    nxt       = cur;
    nxt.rdy0  = cur.rdy0 | hit0;
    nxt.rdy1  = cur.rdy1 | hit1;
    nxt.fresh = became_ready && wake_fast;
  end
endmodule

// File: rtl/iq_oldest_pick.sv
module iq_oldest_pick #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     elig,
  output logic [N-1:0]     grant,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) idx = IDX_W'(i);
    end
    any   = |elig;
    grant = any ? (N'(1) << idx) : '0;
  end

  // R5: never more than one grant
  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(grant));
  // R4: nothing eligible sits below the granted position
  p_oldest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (((grant - N'(1)) & elig) == '0));
  // R4: grant only goes to an eligible slot
  p_grant_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~elig) == '0);
endmodule

// File: rtl/age_issue_queue.sv
module age_issue_queue
  import iqs_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int SLOW_N = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                disp_valid,
  input  logic [IQ_ID_W-1:0]  disp_id,
  input  logic [IQ_TAG_W-1:0] disp_tag0,
  input  logic                disp_rdy0,
  input  logic [IQ_TAG_W-1:0] disp_tag1,
  input  logic                disp_rdy1,
  output logic                disp_full,
  input  logic                wake_valid,
  input  logic [IQ_TAG_W-1:0] wake_tag,
  input  logic                wake_fast,
  output logic                issue_valid,
  output logic [IQ_ID_W-1:0]  issue_id
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int IDX_W = $clog2(DEPTH);

  iq_ent_t          ent_q [DEPTH];
  iq_ent_t          ent_d [DEPTH];
  iq_ent_t          woke  [DEPTH+1];
  iq_ent_t          disp_raw, disp_woke;
  logic [CNT_W-1:0] cnt_q, cnt_d, base;
  logic [DEPTH-1:0] slot_live, elig, slow_hold, grant;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any, full, issue_fire, disp_acc;

  assign full       = (cnt_q == CNT_W'(DEPTH));
  assign issue_fire = pick_any && !flush;
  assign disp_acc   = disp_valid && !full && !flush;
  assign base       = cnt_q - CNT_W'(issue_fire);

  // per-slot wakeup and eligibility
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign slot_live[g] = CNT_W'(g) < cnt_q;
      assign slow_hold[g] = slot_live[g] && ent_ready(ent_q[g]) &&
                            slow_blocked(ent_q[g], full, g, SLOW_N);
      assign elig[g]      = slot_live[g] && ent_ready(ent_q[g]) && !slow_hold[g];
      iq_wake_cell u_wake (
        .cur(ent_q[g]), .wake_valid(wake_valid), .wake_tag(wake_tag),
        .wake_fast(wake_fast), .nxt(woke[g])
      );
    end
  endgenerate
  assign woke[DEPTH] = '0;

  // incoming micro-op also sees this cycle's broadcast
  always_comb begin
    disp_raw       = '0;
    disp_raw.id    = disp_id;
    disp_raw.tag0  = disp_tag0;
    disp_raw.rdy0  = disp_rdy0;
    disp_raw.tag1  = disp_tag1;
    disp_raw.rdy1  = disp_rdy1;
  end

  iq_wake_cell u_disp_wake (
    .cur(disp_raw), .wake_valid(wake_valid), .wake_tag(wake_tag),
    .wake_fast(wake_fast), .nxt(disp_woke)
  );

  iq_oldest_pick #(.N(DEPTH)) u_pick (
    .clk(clk), .rst_n(rst_n), .elig(elig), .grant(grant), .any(pick_any), .idx(pick_idx)
  );

  // compaction: slots at or above the issued one move down by one
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (issue_fire && (IDX_W'(i) >= pick_idx)) ent_d[i] = woke[i+1];
      else                                      ent_d[i] = woke[i];
      if (disp_acc && (CNT_W'(i) == base))      ent_d[i] = disp_woke;
    end
    if (flush) cnt_d = '0;
    else       cnt_d = base + CNT_W'(disp_acc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign disp_full   = full;
  assign issue_valid = issue_fire;
  assign issue_id    = ent_q[pick_idx].id;

  // R2: occupancy bounded
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n) cnt_q <= CNT_W'(DEPTH));
  // R2: a full queue only shrinks by the issued entry
  p_full_refuses_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_full && !flush) |=> (cnt_q == $past(cnt_q) - CNT_W'($past(issue_valid))));
  // R8: flush empties the queue
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (cnt_q == '0 && !issue_valid));
  // R6: a held entry costs exactly one cycle, so something issues next cycle
  p_slow_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((|slow_hold) && !flush) |=> (issue_valid || flush));
  // R3: an issuable entry is never left unserved
  p_ready_issues_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((|elig) && !flush) |-> issue_valid);
endmodule

// File: tb/age_issue_queue_test.sv
module age_issue_queue_test;
  localparam int DEPTH  = 16;
  localparam int SLOW_N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0, disp_valid = 1'b0, disp_rdy0 = 1'b0, disp_rdy1 = 1'b0;
  logic [7:0] disp_id = '0;
  logic [5:0] disp_tag0 = '0, disp_tag1 = '0, wake_tag = '0;
  logic       wake_valid = 1'b0, wake_fast = 1'b0;
  logic       disp_full, issue_valid;
  logic [7:0] issue_id;

  age_issue_queue #(.DEPTH(DEPTH), .SLOW_N(SLOW_N)) uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .disp_valid(disp_valid), .disp_id(disp_id),
    .disp_tag0(disp_tag0), .disp_rdy0(disp_rdy0), .disp_tag1(disp_tag1), .disp_rdy1(disp_rdy1),
    .disp_full(disp_full), .wake_valid(wake_valid), .wake_tag(wake_tag), .wake_fast(wake_fast),
    .issue_valid(issue_valid), .issue_id(issue_id)
  );

  always #5 clk = ~clk;

  typedef struct { int id; int t0; bit r0; int t1; bit r1; bit fresh; } ment_t;
  ment_t mq[$];
  int    n_chk = 0, n_err = 0;
  string cur_req = "R1";
  bit    done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock: drive at the falling edge, compare against the model, then advance the model
  task automatic tick(input bit dv, input int id, input int t0, input bit r0, input int t1,
                      input bit r1, input bit wv, input int wt, input bit wf, input bit fl);
    bit m_full;
    int pick;
    @(negedge clk);
    disp_valid = dv; disp_id = 8'(id); disp_tag0 = 6'(t0); disp_rdy0 = r0;
    disp_tag1 = 6'(t1); disp_rdy1 = r1; wake_valid = wv; wake_tag = 6'(wt);
    wake_fast = wf; flush = fl;
    #1;
    m_full = (mq.size() == DEPTH);
    pick = -1;
    for (int i = 0; i < mq.size(); i++) begin
      if (pick < 0 && mq[i].r0 && mq[i].r1 && !(mq[i].fresh && m_full && i < SLOW_N)) pick = i;
    end
    chk(disp_full == m_full, cur_req, "disp_full", int'(disp_full), int'(m_full));
    chk(issue_valid == (!fl && pick >= 0), cur_req, "issue_valid", int'(issue_valid),
        int'(!fl && pick >= 0));
    if (!fl && pick >= 0) chk(int'(issue_id) == mq[pick].id, cur_req, "issue_id",
                              int'(issue_id), mq[pick].id);
    if (fl) mq.delete();
    else begin
      if (pick >= 0) mq.delete(pick);
      foreach (mq[i]) begin
        bit was;
        was = mq[i].r0 && mq[i].r1;
        if (wv && mq[i].t0 == wt) mq[i].r0 = 1;
        if (wv && mq[i].t1 == wt) mq[i].r1 = 1;
        mq[i].fresh = !was && mq[i].r0 && mq[i].r1 && wf;
      end
      if (dv && !m_full) begin
        ment_t n;
        n.id = id; n.t0 = t0; n.t1 = t1;
        n.r0 = r0 || (wv && t0 == wt);
        n.r1 = r1 || (wv && t1 == wt);
        n.fresh = !(r0 && r1) && n.r0 && n.r1 && wf;
        mq.push_back(n);
      end
    end
  endtask

  task automatic idle();
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic do_flush();
    tick(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(issue_valid == 0, "R1", "reset issue_valid", int'(issue_valid), 0);
    chk(disp_full == 0, "R1", "reset disp_full", int'(disp_full), 0);

    // R6: full queue, fast wakeup, oldest four wait one cycle
    cur_req = "R6";
    for (int k = 0; k < DEPTH; k++) tick(1, 16 + k, 5, 0, 0, 1, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 1, 5, 1, 0);
    chk(disp_full == 1, "R2", "full after 16", int'(disp_full), 1);
    idle();
    chk(issue_valid && issue_id == 8'd20, "R6", "younger issues past slow zone", int'(issue_id), 20);
    idle();
    chk(issue_valid && issue_id == 8'd16, "R6", "oldest issues one cycle later", int'(issue_id), 16);
    do_flush();

    // R7 and R2: slow producer, no penalty; refused dispatch never appears
    cur_req = "R7";
    for (int k = 0; k < DEPTH; k++) tick(1, 40 + k, 6, 0, 0, 1, 0, 0, 0, 0);
    tick(1, 200, 0, 1, 0, 1, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 1, 6, 0, 0);
    idle();
    chk(issue_valid && issue_id == 8'd40, "R7", "slow producer no penalty", int'(issue_id), 40);
    for (int k = 0; k < DEPTH - 1; k++) idle();
    idle();
    chk(issue_valid == 0, "R2", "refused dispatch dropped", int'(issue_valid), 0);

    // R7: fast wakeup below full, no penalty
    for (int k = 0; k < DEPTH - 1; k++) tick(1, 60 + k, 7, 0, 0, 1, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 1, 7, 1, 0);
    idle();
    chk(issue_valid && issue_id == 8'd60, "R7", "not full no penalty", int'(issue_id), 60);
    do_flush();

    // R3: wakeup in the dispatch cycle, and normal one-cycle wakeup
    cur_req = "R3";
    tick(1, 90, 9, 0, 0, 1, 1, 9, 1, 0);
    idle();
    chk(issue_valid && issue_id == 8'd90, "R3", "same-cycle wake at dispatch", int'(issue_id), 90);
    tick(1, 91, 10, 0, 0, 1, 0, 0, 0, 0);
    idle();
    chk(issue_valid == 0, "R3", "pending not issued", int'(issue_valid), 0);
    tick(0, 0, 0, 0, 0, 0, 1, 10, 0, 0);
    chk(issue_valid == 0, "R3", "not issued in wake cycle", int'(issue_valid), 0);
    idle();
    chk(issue_valid && issue_id == 8'd91, "R3", "issue cycle after wake", int'(issue_id), 91);

    // R4/R5: oldest-first among ready entries
    cur_req = "R4";
    tick(1, 100, 0, 1, 11, 0, 0, 0, 0, 0);
    tick(1, 101, 0, 1, 12, 0, 0, 0, 0, 0);
    tick(1, 102, 0, 1, 11, 0, 0, 0, 0, 0);
    tick(1, 103, 0, 1, 0, 1, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 1, 12, 1, 0);
    chk(issue_valid && issue_id == 8'd103, "R4", "only ready entry", int'(issue_id), 103);
    tick(0, 0, 0, 0, 0, 0, 1, 11, 1, 0);
    chk(issue_valid && issue_id == 8'd101, "R4", "woken entry", int'(issue_id), 101);
    idle();
    chk(issue_valid && issue_id == 8'd100, "R4", "oldest of two ready", int'(issue_id), 100);
    idle();
    chk(issue_valid && issue_id == 8'd102, "R5", "one per cycle", int'(issue_id), 102);

    // R8: flush suppresses issue and dispatch
    cur_req = "R8";
    tick(1, 110, 0, 1, 0, 1, 0, 0, 0, 0);
    tick(1, 111, 0, 1, 0, 1, 0, 0, 0, 0);
    chk(issue_valid && issue_id == 8'd110, "R8", "issue before flush", int'(issue_id), 110);
    tick(1, 112, 0, 1, 0, 1, 0, 0, 0, 1);
    chk(issue_valid == 0, "R8", "no issue in flush cycle", int'(issue_valid), 0);
    idle();
    chk(issue_valid == 0 && disp_full == 0, "R8", "empty after flush", int'(issue_valid), 0);

    // random mix against the model
    cur_req = "R5";
    for (int c = 0; c < 4000; c++) begin
      tick(($urandom % 4) != 0, $urandom % 256, $urandom % 8, ($urandom % 3) == 0,
           $urandom % 8, ($urandom % 2) == 0, ($urandom % 3) != 0, $urandom % 8,
           ($urandom % 2) == 0, ($urandom % 300) == 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule